// File: doc/BRIEF.md
# Bit-band alias bus bridge

This bridge sits between a processor bus master and a byte-addressable memory port. Two alias windows are decoded, each 32 MB long, one at 0x2200_0000 and one at 0x4200_0000. Inside a window every 32-bit alias word stands for one bit of a target region. A read through the alias returns that bit alone. A write through the alias sets or clears that bit and leaves the rest of the target unit as it was. The write is done as a read-modify-write that holds the memory locked from the read until the write is accepted.

Accesses may be one byte, one halfword or one word wide. The access unit always sits in the low bits of every data bus, as a little-endian value. Addresses outside both windows go to the memory port unchanged, as one transaction. Both ports use a valid/ready request handshake. Read data comes back on a separate `mem_rvalid` strobe, one response per read. Each upstream access ends with a one-cycle `up_done` pulse.

Top module: `bb_bridge`

## Requirements
- R1: An address is an alias address when it lies in [0x2200_0000, 0x2400_0000) or in [0x4200_0000, 0x4400_0000). Any other address, including 0x2400_0000 and 0x41FF_FFFC, is passed through.
- R2: For an alias access, the target byte address keeps alias bits [31:29] and ORs in alias bits [24:0] shifted right by 5.
- R3: The bit index is alias bits [6:2] masked to 3, 4 or 5 bits, for sizes byte (0), halfword (1) and word (2). For a halfword the target address is aligned down to 2 bytes, and for a word it is aligned down to 4 bytes.
- R4: An alias read issues one unlocked memory read of the target unit. It returns `up_rdata` = 1 when the selected bit is set and 0 otherwise, with bits [31:1] zero.
- R5: An alias write first reads the target unit and then writes it back. In the written value the selected bit equals `up_wdata[0]`, all other unit bits equal the value read, and bits above the unit are zero.
- R6: Both phases of an alias write carry `mem_lock`=1. No other memory transaction comes between them, and the lock falls only after the write phase is accepted.
- R7: A pass-through access makes exactly one unlocked memory transaction with the original address, size and write data. For a read, `up_rdata` equals `mem_rdata` unchanged.
- R8: Size code 3 is illegal. It ends the access with `up_err`=1 and makes no memory transaction. Legal accesses give `up_err`=0.
- R9: `up_ready` is high only while the bridge is idle. `up_done` is a one-cycle pulse that comes after the last memory phase has been accepted or answered. A memory request holds steady until `mem_ready`.
- R10: After reset, `up_ready`=1 and `mem_valid`, `mem_lock` and `up_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge idle and accepting a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Upstream byte address |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| up_wdata | input | 32 | Write data, unit in low bits |
| up_done | output | 1 | One-cycle completion pulse |
| up_rdata | output | 32 | Read result, valid with up_done |
| up_err | output | 1 | Illegal size, valid with up_done |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Memory access size code |
| mem_wdata | output | 32 | Memory write data, unit in low bits |
| mem_lock | output | 1 | Memory held for a read-modify-write |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data, unit in low bits |

## Verification
The assertions assume that the memory raises `mem_rvalid` exactly once for each accepted read, after that read has been accepted, and never for a write. They also assume the master holds its request stable while `up_valid` is high and `up_ready` is low. The bench memory responder answers every accepted read once, on the next cycle. It stalls `mem_ready` in a fixed irregular pattern and fills the bits above the unit with junk, so that the bridge's masking is exercised. The stimulus task changes the upstream request only at falling edges, and only while the request is not yet accepted.

// File: rtl/bb_pkg.sv
package bb_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PASS,
      ST_PWAIT,
      ST_ARD,
      ST_AWAIT,
      ST_AWR,
      ST_DONE
   } br_state_e;

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
   import bb_pkg::*;
#(
   parameter int                     ADDR_W    = 32,
   parameter int                     NWIN      = 2,
   parameter logic [NWIN*ADDR_W-1:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000},
   parameter logic [ADDR_W-1:0]      WIN_BYTES = 32'h0200_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   output logic              hit,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [4:0]        bit_idx
);

   localparam int WIN_LSB = $clog2(WIN_BYTES);
   localparam logic [ADDR_W-1:0] OFF_MASK = WIN_BYTES - 1'b1;
   localparam logic [ADDR_W-1:0] SEG_MASK = {3'b111, {(ADDR_W-3){1'b0}}};

   if (ADDR_W < 8) begin : g_bad_aw
      $error("bb_addr_map: ADDR_W too small");
   end
   if ((WIN_BYTES & OFF_MASK) != '0) begin : g_bad_win
      $error("bb_addr_map: WIN_BYTES must be a power of two");
   end
   if (WIN_LSB + 3 > ADDR_W) begin : g_bad_lsb
      $error("bb_addr_map: window overlaps the kept segment bits");
   end

   logic [NWIN-1:0] win_hit;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      localparam logic [ADDR_W:0] LO = {1'b0, WIN_BASES[i*ADDR_W +: ADDR_W]};
      localparam logic [ADDR_W:0] HI = LO + {1'b0, WIN_BYTES};
      if ((LO[ADDR_W-1:0] & OFF_MASK) != '0) begin : g_bad_base
         $error("bb_addr_map: window base not aligned to its size");
      end
      assign win_hit[i] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
   end

   assign hit = |win_hit;

   logic [ADDR_W-1:0] raw;
   assign raw = (addr & SEG_MASK) | ((addr & OFF_MASK) >> 5);

   logic [4:0] sel;
   assign sel = addr[6:2];

   always_comb begin
      unique case (size)
         SZ_HALF: begin
            tgt_addr = {raw[ADDR_W-1:1], 1'b0};
            bit_idx  = {1'b0, sel[3:0]};
         end
         SZ_WORD: begin
            tgt_addr = {raw[ADDR_W-1:2], 2'b00};
            bit_idx  = sel;
         end
         default: begin
            tgt_addr = raw;
            bit_idx  = {2'b00, sel[2:0]};
         end
      endcase
   end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
   import bb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e         size,
   input  logic [4:0]        bit_idx,
   input  logic [DATA_W-1:0] unit_in,
   input  logic              set_bit,
   output logic              bit_val,
   output logic [DATA_W-1:0] unit_old,
   output logic [DATA_W-1:0] unit_out
);

   localparam int NLANE = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_dw
      $error("bb_bit_merge: the bit index spans a 32-bit unit only");
   end

   logic [NLANE-1:0]  lane_en;
   logic [DATA_W-1:0] mask;

   always_comb begin
      unique case (size)
         SZ_HALF: lane_en = NLANE'(2'b11);
         SZ_WORD: lane_en = '1;
         default: lane_en = NLANE'(1'b1);
      endcase
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      assign mask[l*8 +: 8] = {8{lane_en[l]}};
   end

   logic [DATA_W-1:0] sel;
   assign sel      = DATA_W'(1) << bit_idx;
   assign unit_old = unit_in & mask;
   assign bit_val  = |(unit_old & sel);
   assign unit_out = set_bit ? (unit_old | sel) : (unit_old & ~sel);

endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
   import bb_pkg::*;
#(
   parameter int                     ADDR_W    = 32,
   parameter int                     DATA_W    = 32,
   parameter int                     NWIN      = 2,
   parameter logic [NWIN*ADDR_W-1:0] WIN_BASES = {32'h4200_0000, 32'h2200_0000},
   parameter logic [ADDR_W-1:0]      WIN_BYTES = 32'h0200_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic              up_write,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [1:0]        up_size,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_done,
   output logic [DATA_W-1:0] up_rdata,
   output logic              up_err,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_lock,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (NWIN < 1) begin : g_bad_nwin
      $error("bb_bridge: at least one alias window is needed");
   end

   br_state_e         state;
   logic              req_write;
   logic [ADDR_W-1:0] req_addr;
   acc_size_e         req_size;
   logic [DATA_W-1:0] req_wdata;
   logic              req_alias;
   logic              err_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] wr_q;
   logic [DATA_W-1:0] old_q;

   logic              map_hit;
   logic [ADDR_W-1:0] tgt_addr;
   logic [4:0]        bit_idx;
   logic              bit_val;
   logic [DATA_W-1:0] unit_old;
   logic [DATA_W-1:0] unit_new;

   bb_addr_map #(
      .ADDR_W(ADDR_W), .NWIN(NWIN), .WIN_BASES(WIN_BASES), .WIN_BYTES(WIN_BYTES)
   ) i_map (
      .addr(req_addr), .size(req_size), .hit(map_hit),
      .tgt_addr(tgt_addr), .bit_idx(bit_idx)
   );

   bb_bit_merge #(.DATA_W(DATA_W)) i_merge (
      .size(req_size), .bit_idx(bit_idx), .unit_in(mem_rdata),
      .set_bit(req_wdata[0]), .bit_val(bit_val),
      .unit_old(unit_old), .unit_out(unit_new)
   );

   // Request decode on the incoming address, used at acceptance
   logic              in_hit;
   logic [ADDR_W-1:0] in_tgt_unused;
   logic [4:0]        in_idx_unused;

   bb_addr_map #(
      .ADDR_W(ADDR_W), .NWIN(NWIN), .WIN_BASES(WIN_BASES), .WIN_BYTES(WIN_BYTES)
   ) i_map_in (
      .addr(up_addr), .size(acc_size_e'(up_size)), .hit(in_hit),
      .tgt_addr(in_tgt_unused), .bit_idx(in_idx_unused)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_size  <= SZ_BYTE;
         req_wdata <= '0;
         req_alias <= 1'b0;
         err_q     <= 1'b0;
         rdata_q   <= '0;
         wr_q      <= '0;
         old_q     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (up_valid) begin
               req_write <= up_write;
               req_addr  <= up_addr;
               req_size  <= acc_size_e'(up_size);
               req_wdata <= up_wdata;
               req_alias <= in_hit;
               rdata_q   <= '0;
               err_q     <= (up_size == SZ_BAD);
               if (up_size == SZ_BAD) state <= ST_DONE;
               else if (in_hit)       state <= ST_ARD;
               else                   state <= ST_PASS;
            end
            ST_PASS: if (mem_ready) state <= req_write ? ST_DONE : ST_PWAIT;
            ST_PWAIT: if (mem_rvalid) begin
               rdata_q <= mem_rdata;
               state   <= ST_DONE;
            end
            ST_ARD: if (mem_ready) state <= ST_AWAIT;
            ST_AWAIT: if (mem_rvalid) begin
               wr_q    <= unit_new;
               old_q   <= unit_old;
               rdata_q <= DATA_W'(bit_val);
               state   <= req_write ? ST_AWR : ST_DONE;
            end
            ST_AWR: if (mem_ready) state <= ST_DONE;
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign up_ready = (state == ST_IDLE);
   assign up_done  = (state == ST_DONE);
   assign up_rdata = rdata_q;
   assign up_err   = up_done && err_q;

   always_comb begin
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = req_addr;
      mem_size  = req_size;
      mem_wdata = '0;
      mem_lock  = 1'b0;
      unique case (state)
         ST_PASS: begin
            mem_valid = 1'b1;
            mem_write = req_write;
            mem_wdata = req_wdata;
         end
         ST_ARD: begin
            mem_valid = 1'b1;
            mem_addr  = tgt_addr;
            mem_lock  = req_write;
         end
         ST_AWAIT: begin
            mem_addr  = tgt_addr;
            mem_lock  = req_write;
         end
         ST_AWR: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = tgt_addr;
            mem_wdata = wr_q;
            mem_lock  = 1'b1;
         end
         default: ;
      endcase
   end

   p_lock_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_lock) |-> $past(mem_valid && mem_ready && mem_write));

   p_lock_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && req_alias && req_write) |-> mem_lock);

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
         $stable(mem_size) && $stable(mem_write) && $stable(mem_wdata)));

   p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready) |=> !up_ready);

   p_bit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (up_done && req_alias && !req_write && !err_q) |-> (up_rdata[DATA_W-1:1] == '0));

   p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && mem_lock) |-> ($countones(mem_wdata ^ old_q) <= 1));

   p_bad_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready && up_size == 2'd3) |=> (!mem_valid && up_done && up_err));

endmodule

// File: tb/test_bb_bridge.sv
module test_bb_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic        up_write = 1'b0;
   logic [31:0] up_addr = '0;
   logic [1:0]  up_size = '0;
   logic [31:0] up_wdata = '0;
   logic        up_done;
   logic [31:0] up_rdata;
   logic        up_err;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic        mem_write;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [31:0] mem_wdata;
   logic        mem_lock;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2 clk = ~clk;

   bb_bridge i_bb_bridge (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
      .up_addr(up_addr), .up_size(up_size), .up_wdata(up_wdata),
      .up_done(up_done), .up_rdata(up_rdata), .up_err(up_err),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_lock(mem_lock), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;

   typedef struct {
      bit          wr;
      logic [31:0] a;
      logic [1:0]  sz;
      logic [31:0] wd;
      bit          lk;
   } txn_t;

   txn_t            log_q[$];
   logic [7:0]      mem_m[int unsigned];

   function automatic logic [7:0] get_byte(input logic [31:0] a);
      if (mem_m.exists(a)) return mem_m[a];
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   function automatic int unsigned nbytes(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] unit_of(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] v = '0;
      for (int i = 0; i < int'(nbytes(sz)); i++) v[i*8 +: 8] = get_byte(a + i);
      return v;
   endfunction

   function automatic logic [31:0] junk_of(input logic [31:0] a, input logic [1:0] sz);
      logic [31:0] v = unit_of(a, sz);
      for (int i = int'(nbytes(sz)); i < 4; i++) v[i*8 +: 8] = 8'hA5;
      return v;
   endfunction

   int unsigned pat = 32'h1234_5677;

   // Memory responder: irregular ready, one-cycle read latency, junk above the unit
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready  <= 1'b0;
         mem_rvalid <= 1'b0;
      end else begin
         mem_rvalid <= 1'b0;
         if (mem_valid && mem_ready) begin
            log_q.push_back('{wr: mem_write, a: mem_addr, sz: mem_size,
                              wd: mem_wdata, lk: mem_lock});
            if (mem_write) begin
               for (int i = 0; i < int'(nbytes(mem_size)); i++)
                  mem_m[mem_addr + i] = mem_wdata[i*8 +: 8];
            end else begin
               mem_rdata  <= junk_of(mem_addr, mem_size);
               mem_rvalid <= 1'b1;
            end
         end
         pat = pat * 1103515245 + 12345;
         mem_ready <= pat[16] | pat[19];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit in_alias(input logic [31:0] a);
      return (a >= 32'h2200_0000 && a < 32'h2400_0000) ||
             (a >= 32'h4200_0000 && a < 32'h4400_0000);
   endfunction

   // One upstream access, checked against the behavioural model
   task automatic access(input bit wr, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, input string req);
      bit          alias_hit = in_alias(a);
      logic [31:0] tgt;
      logic [4:0]  idx;
      logic [31:0] old_u;
      logic [31:0] new_u;
      logic [31:0] exp_rd;
      txn_t        exp_q[$];
      bit          busy_ok = 1'b1;

      tgt = (a & 32'hE000_0000) | ((a & 32'h01FF_FFFF) >> 5);
      if (sz == 2'd1) tgt = tgt & ~32'd1;
      if (sz == 2'd2) tgt = tgt & ~32'd3;
      idx = (sz == 2'd0) ? 5'((a >> 2) & 7) : (sz == 2'd1) ? 5'((a >> 2) & 15) : 5'((a >> 2) & 31);
      exp_rd = '0;
      if (sz == 2'd3) begin
         // no transactions expected
      end else if (alias_hit) begin
         old_u = unit_of(tgt, sz);
         new_u = wd[0] ? (old_u | (32'd1 << idx)) : (old_u & ~(32'd1 << idx));
         exp_q.push_back('{wr: 1'b0, a: tgt, sz: sz, wd: '0, lk: wr});
         if (wr) exp_q.push_back('{wr: 1'b1, a: tgt, sz: sz, wd: new_u, lk: 1'b1});
         else    exp_rd = 32'(old_u[idx]);
      end else begin
         exp_q.push_back('{wr: wr, a: a, sz: sz, wd: wd, lk: 1'b0});
         if (!wr) exp_rd = junk_of(a, sz);
      end

      log_q.delete();
      @(negedge clk);
      up_valid = 1'b1; up_write = wr; up_addr = a; up_size = sz; up_wdata = wd;
      while (!up_ready) @(negedge clk);
      @(negedge clk);
      up_valid = 1'b0;
      while (!up_done) begin
         if (up_ready) busy_ok = 1'b0;
         @(negedge clk);
      end
      chk(busy_ok, "R9", "up_ready low while busy", 32'(busy_ok), 32'd1);
      chk(up_err == (sz == 2'd3), "R8", "error flag", 32'(up_err), 32'(sz == 2'd3));
      if (!wr && sz != 2'd3)
         chk(up_rdata == exp_rd, alias_hit ? "R4" : "R7", "read result", up_rdata, exp_rd);
      chk(log_q.size() == exp_q.size(), (sz == 2'd3) ? "R8" : alias_hit ? "R6" : "R7",
          "memory transaction count", 32'(log_q.size()), 32'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < log_q.size(); i++) begin
         chk(log_q[i].wr == exp_q[i].wr, alias_hit ? "R5" : "R7", "txn direction",
             32'(log_q[i].wr), 32'(exp_q[i].wr));
         chk(log_q[i].a == exp_q[i].a, alias_hit ? "R2" : "R1", "txn address",
             log_q[i].a, exp_q[i].a);
         chk(log_q[i].sz == exp_q[i].sz, alias_hit ? "R3" : "R7", "txn size",
             32'(log_q[i].sz), 32'(exp_q[i].sz));
         chk(log_q[i].lk == exp_q[i].lk, "R6", "txn lock",
             32'(log_q[i].lk), 32'(exp_q[i].lk));
         if (exp_q[i].wr)
            chk(log_q[i].wd == exp_q[i].wd, alias_hit ? "R5" : "R7", "txn write data",
                log_q[i].wd, exp_q[i].wd);
      end
      @(negedge clk);
      chk(up_done == 1'b0, "R9", "done is one cycle", 32'(up_done), 32'd0);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL R9 watchdog: actual %0d expected <150000 cycles", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   function automatic logic [31:0] alias_of(input logic [31:0] base, input logic [31:0] byte_off,
                                            input int bitn);
      return base + (byte_off << 5) + (32'(bitn) << 2);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(up_ready == 1'b1, "R10", "reset up_ready", 32'(up_ready), 32'd1);
      chk(mem_valid == 1'b0, "R10", "reset mem_valid", 32'(mem_valid), 32'd0);
      chk(mem_lock == 1'b0, "R10", "reset mem_lock", 32'(mem_lock), 32'd0);
      chk(up_done == 1'b0, "R10", "reset up_done", 32'(up_done), 32'd0);
      rst_n = 1'b1;

      // R3 R4 R5: all sizes, bit indices at both ends, both windows
      for (int w = 0; w < 2; w++) begin
         for (int s = 0; s < 3; s++) begin
            logic [31:0] base = (w == 0) ? 32'h2200_0000 : 32'h4200_0000;
            int          top  = (s == 0) ? 7 : (s == 1) ? 15 : 31;
            for (int e = 0; e < 2; e++) begin
               int          b  = (e == 0) ? 0 : top;
               logic [31:0] a  = alias_of(base, 32'h0000_0104 + 32'(s * 16), b);
               access(1'b0, a, 2'(s), 32'h0, "R4");
               access(1'b1, a, 2'(s), 32'hFFFF_FFFF, "R5");
               access(1'b0, a, 2'(s), 32'h0, "R4");
               access(1'b1, a, 2'(s), 32'hFFFF_FFFE, "R5");
               access(1'b0, a, 2'(s), 32'h0, "R4");
            end
         end
      end

      // R3: odd byte offsets under halfword and word alignment
      access(1'b1, alias_of(32'h2200_0000, 32'h0000_0207, 13), 2'd1, 32'd1, "R3");
      access(1'b1, alias_of(32'h4200_0000, 32'h0000_0303, 29), 2'd2, 32'd1, "R3");
      access(1'b0, alias_of(32'h4200_0000, 32'h0000_0303, 29), 2'd2, 32'd0, "R3");

      // R1: window edges
      access(1'b0, 32'h23FF_FFFC, 2'd2, 32'h0, "R1");
      access(1'b1, 32'h43FF_FFFC, 2'd0, 32'd1, "R1");
      access(1'b0, 32'h2400_0000, 2'd2, 32'h0, "R1");
      access(1'b0, 32'h41FF_FFFC, 2'd2, 32'h0, "R1");
      access(1'b0, 32'h21FF_FFF8, 2'd1, 32'h0, "R1");

      // R7: pass-through read and write in every size
      access(1'b1, 32'h2000_0010, 2'd2, 32'hDEAD_BEEF, "R7");
      access(1'b0, 32'h2000_0010, 2'd2, 32'h0, "R7");
      access(1'b1, 32'h2000_0013, 2'd0, 32'h0000_0077, "R7");
      access(1'b0, 32'h2000_0012, 2'd1, 32'h0, "R7");
      access(1'b0, 32'h2000_0013, 2'd0, 32'h0, "R7");

      // R5 after R7: alias write lands on a byte just written directly
      access(1'b1, alias_of(32'h2200_0000, 32'h0000_0013, 3), 2'd0, 32'h0, "R5");
      access(1'b0, 32'h2000_0010, 2'd2, 32'h0, "R5");

      // R8: illegal size on both kinds of address
      access(1'b1, 32'h2200_0040, 2'd3, 32'd1, "R8");
      access(1'b0, 32'h2000_0000, 2'd3, 32'd0, "R8");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule